// File: doc/BRIEF.md
# Bidirectional Digital Ramp Generator

This block produces a 32-bit ramp that steers one control parameter of a direct digital synthesizer: output frequency, output phase or output amplitude. The ramp lives between a lower and an upper limit that software sets. The rising and falling segments each have their own step size and their own step interval. An external direction pin picks which segment is active, and a hold pin freezes the ramp where it is.

Parameters are loaded through a small register write port into a shadow bank. They reach the working bank only when an update strobe is pulsed, so a full parameter set changes in a single cycle. The block outputs the raw ramp value, a word formatted for the selected destination, and a flag that shows the ramp is parked at the limit it is heading toward.

Top module: `ramp_gen`

## Requirements
- R1: After reset the ramp value is 0, which is the reset lower limit. The reset upper limit is 0xFFFFFFFF, both step sizes and both step intervals are 0, and the destination is frequency.
- R2: Writes to the write port only touch the shadow bank. The working parameters change only on a cycle where `update` is high, and that cycle copies the shadow contents as they stood before any write in the same cycle. Register map: address 0 is the lower limit, 1 the upper limit, 2 the rising step, 3 the falling step, 4 the intervals (bits 15:0 rising, bits 31:16 falling), and 5 the destination (bits 1:0).
- R3: With `ramp_dir` = 1 and hold low, the value increases by the rising step once every rising interval + 1 cycles.
- R4: With `ramp_dir` = 0 and hold low, the value decreases by the falling step once every falling interval + 1 cycles.
- R5: A rising step that would pass the upper limit, or overflow 32 bits, leaves the value at the upper limit. The value never wraps.
- R6: A falling step that would pass the lower limit, or go below zero, leaves the value at the lower limit. The value never wraps.
- R7: While `ramp_hold` is high, the ramp value and both interval counters are frozen.
- R8: `at_limit` is high exactly when the value equals the upper limit with `ramp_dir` = 1, or equals the lower limit with `ramp_dir` = 0.
- R9: `param_out` follows the destination code. Codes 0 and 3 (frequency) give the full value. Code 1 (phase) gives the value's top 16 bits, zero-extended. Code 2 (amplitude) gives its top 14 bits, zero-extended.
- R10: The rising and falling interval counters are separate. Each one counts only while its direction is selected and keeps its count while the other direction is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Shadow register write enable |
| wr_addr | input | 3 | Shadow register address |
| wr_data | input | 32 | Shadow register write data |
| update | input | 1 | Copy the shadow bank to the working bank |
| ramp_dir | input | 1 | 1 = rising, 0 = falling |
| ramp_hold | input | 1 | Freeze the ramp and its counters |
| ramp_out | output | 32 | Current ramp value |
| param_out | output | 32 | Value formatted for the selected destination |
| at_limit | output | 1 | Value sits at the limit of the current direction |

## Verification
The assertions watch a few things on every cycle. The value never moves under hold. The working bank never changes without an update. A ramp that starts inside its limits never steps backwards against its direction. A flagged limit holds the value still. The amplitude and phase words carry no stray high bits. Step sizes, the exact interval cadence, the independence of the two counters and saturation at full scale can only be shown by the bench. It compares every cycle against its own model while it toggles direction and hold at random, mixed with directed saturation and format cases.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  localparam int unsigned VAL_W  = 32;
  localparam int unsigned RATE_W = 16;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    DST_FREQ     = 2'd0,
    DST_PHASE    = 2'd1,
    DST_AMPL     = 2'd2,
    DST_FREQ_ALT = 2'd3
  } dest_e;

  typedef struct packed {
    logic [VAL_W-1:0]  lo;
    logic [VAL_W-1:0]  hi;
    logic [VAL_W-1:0]  up_step;
    logic [VAL_W-1:0]  dn_step;
    logic [RATE_W-1:0] up_rate;
    logic [RATE_W-1:0] dn_rate;
    dest_e             dest;
  } ramp_cfg_t;

  localparam ramp_cfg_t CFG_RST = '{
    lo: '0, hi: '1, up_step: '0, dn_step: '0,
    up_rate: '0, dn_rate: '0, dest: DST_FREQ
  };
endpackage

// File: rtl/ramp_cfg.sv
module ramp_cfg
  import ramp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [VAL_W-1:0]  wr_data,
  input  logic              update,
  output ramp_cfg_t         act
);
  ramp_cfg_t shd_q, shd_d, act_q, act_d;
  logic      unused_hi_bits;

  assign unused_hi_bits = ^wr_data[VAL_W-1:2];

  always_comb begin
    shd_d = shd_q;
    if (wr_en) begin
      case (wr_addr)
        3'd0: shd_d.lo      = wr_data;
        3'd1: shd_d.hi      = wr_data;
        3'd2: shd_d.up_step = wr_data;
        3'd3: shd_d.dn_step = wr_data;
        3'd4: begin
          shd_d.up_rate = wr_data[RATE_W-1:0];
          shd_d.dn_rate = wr_data[2*RATE_W-1:RATE_W];
        end
        3'd5: shd_d.dest    = dest_e'(wr_data[1:0]);
        default: ;
      endcase
    end
    act_d = update ? shd_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= CFG_RST;
      act_q <= CFG_RST;
    end else begin
      shd_q <= shd_d;
      act_q <= act_d;
    end
  end

  assign act = act_q;
endmodule

// File: rtl/ramp_timer.sv
module ramp_timer #(
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RATE_W-1:0] rate,
  output logic              fire
);
  logic [RATE_W-1:0] cnt_q, cnt_d;

  assign fire = en && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = (cnt_q == '0) ? rate : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ramp_step.sv
module ramp_step
  import ramp_pkg::*;
(
  input  logic [VAL_W-1:0] cur,
  input  logic             rising,
  input  ramp_cfg_t        cfg,
  output logic [VAL_W-1:0] nxt
);
  logic [VAL_W:0]   sum;
  logic [VAL_W-1:0] diff;
  logic             borrow;

  always_comb begin
    sum           = {1'b0, cur} + {1'b0, cfg.up_step};
    {borrow, diff} = {1'b0, cur} - {1'b0, cfg.dn_step};
    if (rising) begin
      if (cur >= cfg.hi || sum > {1'b0, cfg.hi}) nxt = cfg.hi;
      else                                        nxt = sum[VAL_W-1:0];
    end else begin
      if (cur <= cfg.lo || borrow || diff < cfg.lo) nxt = cfg.lo;
      else                                          nxt = diff;
    end
  end
endmodule

// File: rtl/ramp_gen.sv
module ramp_gen
  import ramp_pkg::*;
#(
  parameter int unsigned PHASE_W = 16,
  parameter int unsigned AMPL_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [VAL_W-1:0]  wr_data,
  input  logic              update,
  input  logic              ramp_dir,
  input  logic              ramp_hold,
  output logic [VAL_W-1:0]  ramp_out,
  output logic [VAL_W-1:0]  param_out,
  output logic              at_limit
);
  localparam int unsigned N_DIR = 2;

  logic             rst_s1, rst_s2, core_rst_n;
  ramp_cfg_t        act_cfg;
  logic [N_DIR-1:0] fire_vec;
  logic             step_en;
  logic [VAL_W-1:0] ramp_q, ramp_d, step_val;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s2, rst_s1} <= 2'b00;
    else        {rst_s2, rst_s1} <= {rst_s1, 1'b1};
  end
  assign core_rst_n = rst_s2;

  ramp_cfg u_cfg (
    .clk(clk), .rst_n(core_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .update(update), .act(act_cfg)
  );

  // index 1 = rising interval, index 0 = falling interval
  for (genvar g = 0; g < N_DIR; g++) begin : g_tmr
    ramp_timer #(.RATE_W(RATE_W)) u_tmr (
      .clk  (clk),
      .rst_n(core_rst_n),
      .en   (!ramp_hold && (ramp_dir == (g == 1))),
      .rate ((g == 1) ? act_cfg.up_rate : act_cfg.dn_rate),
      .fire (fire_vec[g])
    );
  end

  assign step_en = |fire_vec;

  ramp_step u_step (
    .cur(ramp_q), .rising(ramp_dir), .cfg(act_cfg), .nxt(step_val)
  );

  always_comb begin
    ramp_d = ramp_q;
    if (step_en) ramp_d = step_val;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) ramp_q <= CFG_RST.lo;
    else             ramp_q <= ramp_d;
  end

  always_comb begin
    case (act_cfg.dest)
      DST_PHASE: param_out = VAL_W'(ramp_q[VAL_W-1 -: PHASE_W]);
      DST_AMPL:  param_out = VAL_W'(ramp_q[VAL_W-1 -: AMPL_W]);
      default:   param_out = ramp_q;
    endcase
  end

  assign ramp_out = ramp_q;
  assign at_limit = ramp_dir ? (ramp_q == act_cfg.hi) : (ramp_q == act_cfg.lo);
endmodule

// File: rtl/ramp_gen_chk.sv
module ramp_gen_chk
  import ramp_pkg::*;
#(
  parameter int unsigned AMPL_W  = 14,
  parameter int unsigned PHASE_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             update,
  input logic             ramp_dir,
  input logic             ramp_hold,
  input logic [VAL_W-1:0] ramp_out,
  input logic [VAL_W-1:0] param_out,
  input logic             at_limit,
  input ramp_cfg_t        act_cfg
);
  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_hold |=> $stable(ramp_out));

  // R2
  cfg_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(act_cfg));

  // R5
  rise_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_dir && !ramp_hold && ramp_out <= act_cfg.hi) |=> ramp_out >= $past(ramp_out));

  // R6
  fall_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ramp_dir && !ramp_hold && ramp_out >= act_cfg.lo) |=> ramp_out <= $past(ramp_out));

  // R8
  limit_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_limit |=> $stable(ramp_out));

  // R9
  ampl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cfg.dest == DST_AMPL) |-> (param_out[VAL_W-1:AMPL_W] == '0));

  // R9
  phase_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cfg.dest == DST_PHASE) |-> (param_out[VAL_W-1:PHASE_W] == '0));
endmodule

bind ramp_gen ramp_gen_chk #(.AMPL_W(AMPL_W), .PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .update(update), .ramp_dir(ramp_dir),
  .ramp_hold(ramp_hold), .ramp_out(ramp_out), .param_out(param_out),
  .at_limit(at_limit), .act_cfg(act_cfg)
);

// File: tb/ramp_gen_bench.sv
module ramp_gen_bench;
  localparam int CLK_P = 10;

  logic        clk, rst_n, wr_en, update, dir, hold;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data, ramp_out, param_out;
  logic        at_limit;

  int n_chk, n_fail;
  string cur_tag;

  // bench model state
  logic [31:0] m_val;
  logic [15:0] m_cu, m_cd;
  logic [31:0] a_lo, a_hi, a_us, a_ds, s_lo, s_hi, s_us, s_ds;
  logic [15:0] a_ur, a_dr, s_ur, s_dr;
  logic [1:0]  a_dst, s_dst;

  ramp_gen u_ramp_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .update(update), .ramp_dir(dir), .ramp_hold(hold),
    .ramp_out(ramp_out), .param_out(param_out), .at_limit(at_limit)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] f_fmt(input logic [31:0] v, input logic [1:0] d);
    case (d)
      2'd1:    return {16'h0, v[31:16]};
      2'd2:    return {18'h0, v[31:18]};
      default: return v;
    endcase
  endfunction

  function automatic logic [31:0] f_step(input logic [31:0] v, input logic r);
    logic [32:0] s;
    if (r) begin
      s = {1'b0, v} + {1'b0, a_us};
      if (v >= a_hi || s > {1'b0, a_hi}) return a_hi;
      return s[31:0];
    end
    if (v <= a_lo || v < a_ds || (v - a_ds) < a_lo) return a_lo;
    return v - a_ds;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic tick(input logic d, input logic h, input logic we,
                      input logic [2:0] a, input logic [31:0] dat, input logic up);
    dir = d; hold = h; wr_en = we; wr_addr = a; wr_data = dat; update = up;
    #1;
    chk(cur_tag, ramp_out, m_val);
    chk("R9", param_out, f_fmt(m_val, a_dst));
    chk("R8", {31'b0, at_limit}, {31'b0, d ? (m_val == a_hi) : (m_val == a_lo)});
    if (!h) begin
      if (d) begin
        if (m_cu == 0) begin m_val = f_step(m_val, 1'b1); m_cu = a_ur; end
        else m_cu = m_cu - 1;
      end else begin
        if (m_cd == 0) begin m_val = f_step(m_val, 1'b0); m_cd = a_dr; end
        else m_cd = m_cd - 1;
      end
    end
    if (up) begin
      a_lo = s_lo; a_hi = s_hi; a_us = s_us; a_ds = s_ds;
      a_ur = s_ur; a_dr = s_dr; a_dst = s_dst;
    end
    if (we) begin
      case (a)
        3'd0: s_lo = dat;
        3'd1: s_hi = dat;
        3'd2: s_us = dat;
        3'd3: s_ds = dat;
        3'd4: begin s_ur = dat[15:0]; s_dr = dat[31:16]; end
        3'd5: s_dst = dat[1:0];
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] dat);
    tick(dir, 1'b1, 1'b1, a, dat, 1'b0);
  endtask

  task automatic run(input logic d, input int n);
    for (int i = 0; i < n; i++) tick(d, 1'b0, 1'b0, 3'd0, 32'd0, 1'b0);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] snap;
    n_chk = 0; n_fail = 0;
    void'($urandom(32'd7321));
    rst_n = 1'b0; wr_en = 0; update = 0; dir = 0; hold = 1; wr_addr = 0; wr_data = 0;
    m_val = 0; m_cu = 0; m_cd = 0;
    a_lo = 0; a_hi = '1; a_us = 0; a_ds = 0; a_ur = 0; a_dr = 0; a_dst = 0;
    s_lo = 0; s_hi = '1; s_us = 0; s_ds = 0; s_ur = 0; s_dr = 0; s_dst = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cur_tag = "R1";
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, 1'b0, 3'd0, 32'd0, 1'b0);
    chk("R1", ramp_out, 32'd0);
    chk("R1", param_out, 32'd0);
    chk("R1", {31'b0, at_limit}, 32'd1);

    // R2: shadow writes must not move the ramp before update
    cur_tag = "R2";
    wr(3'd0, 32'h0000_0100);
    wr(3'd1, 32'h0000_8000);
    wr(3'd2, 32'h0000_0040);
    wr(3'd3, 32'h0000_0030);
    wr(3'd4, 32'h0002_0003);
    run(1'b1, 8);
    chk("R2", ramp_out, 32'd0);
    tick(1'b1, 1'b0, 1'b0, 3'd0, 32'd0, 1'b1);

    cur_tag = "R3";
    snap = m_val;
    run(1'b1, 60);
    chk("R3", ramp_out, m_val);
    cur_tag = "R10";
    run(1'b0, 5);
    run(1'b1, 7);
    cur_tag = "R4";
    run(1'b0, 40);

    // R5: saturation at upper limit, including 32-bit carry
    cur_tag = "R5";
    wr(3'd1, 32'hF000_0000);
    wr(3'd2, 32'h3000_0000);
    tick(1'b1, 1'b0, 1'b0, 3'd0, 32'd0, 1'b1);
    run(1'b1, 30);
    chk("R5", ramp_out, 32'hF000_0000);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd2, 32'hC000_0000);
    tick(1'b1, 1'b0, 1'b0, 3'd0, 32'd0, 1'b1);
    run(1'b1, 20);
    chk("R5", ramp_out, 32'hFFFF_FFFF);
    chk("R8", {31'b0, at_limit}, 32'd1);

    // R6: saturation at lower limit, including borrow
    cur_tag = "R6";
    wr(3'd0, 32'h0000_0010);
    wr(3'd3, 32'hA000_0000);
    tick(1'b0, 1'b0, 1'b0, 3'd0, 32'd0, 1'b1);
    run(1'b0, 20);
    chk("R6", ramp_out, 32'h0000_0010);
    chk("R8", {31'b0, at_limit}, 32'd1);
    cur_tag = "R8";
    tick(1'b1, 1'b1, 1'b0, 3'd0, 32'd0, 1'b0);
    chk("R8", {31'b0, at_limit}, 32'd0);

    // R7: hold freezes value and timers
    cur_tag = "R7";
    run(1'b1, 3);
    snap = ramp_out;
    for (int i = 0; i < 10; i++) tick(1'b1, 1'b1, 1'b0, 3'd0, 32'd0, 1'b0);
    chk("R7", ramp_out, snap);
    run(1'b1, 4);

    // R9: destination formats
    cur_tag = "R9";
    for (int c = 1; c < 4; c++) begin
      wr(3'd5, 32'(c));
      tick(1'b1, 1'b1, 1'b0, 3'd0, 32'd0, 1'b1);
      chk("R9", param_out, f_fmt(ramp_out, 2'(c)));
      run(1'b0, 3);
    end

    // R10: random direction, hold and reprogramming
    cur_tag = "R10";
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      logic [2:0] ad;
      logic [31:0] dt;
      r = $urandom() % 100;
      ad = 3'($urandom() % 6);
      dt = $urandom() >> ($urandom() % 32);
      if (ad == 3'd4) dt = dt & 32'h0007_0007;
      tick(1'($urandom() % 2), (($urandom() % 5) == 0), (r < 3), ad, dt, (r >= 97));
    end

    summary();
    $finish;
  end
endmodule